// File: doc/BRIEF.md
# Per-Processor Local Interrupt Unit

This block holds the interrupt state for the sources that belong to each processor: a timer, a performance counter, a debug channel and two software interrupts. Each processor has its own enable mask, per-source routing registers and an external-controller mode bit. A processor reaches its own copy through a local register window. It can also reach any other processor's copy through a second window. That window is steered by a target index the processor writes first.

The raw pending levels of the sources come in on `srcPend`. The per-source routing capability comes in on `routeCap`. For each processor the block drives a small set of interrupt pins. A source that is pending and enabled raises the pin it is routed to. A source that cannot be routed always lands on a fixed default pin, and the block ignores writes to its routing register.

Register address: bit 4 selects the window (0 for local, 1 for other). Bits 3:0 select the register: 0 control, 1 pending, 2 mask, 3 mask-clear, 4 mask-set, 5 target index (local window only), and 8 to 12 the routing registers of sources 0 to 4. Sources are numbered 0 timer, 1 performance counter, 2 debug channel, 3 and 4 software interrupts.

Top module: `lirq_unit`

## Requirements
- R1: After reset every processor's mask is zero, every target index is 0, external mode is off and every pin is low.
- R2: A write to mask-set (offset 4) sets each mask bit whose data bit is 1, and a write to mask-clear (offset 3) clears each mask bit whose data bit is 1. All other mask bits keep their value. Writing all ones to mask-clear leaves the mask zero. Mask bit n belongs to source n. A read at offset 2 returns the mask.
- R3: A read at offset 1 returns the raw pending levels of the addressed processor in bits 4:0, whatever the mask holds.
- R4: A pin is high exactly when at least one source of that processor is pending, has its mask bit set, and is routed to that pin.
- R5: A processor's target index is written at local offset 5 (bits 1:0) and reads back there. Accesses in the other window go to the processor named by the requester's target index. Writes to offset 5 in the other window have no effect.
- R6: The control register read returns external mode in bit 0 and the routing capability in bits 4:1. Those capability bits are read-only and stand for the timer, the performance counter, the debug channel and both software interrupts, in that order. Only bit 0 is writable.
- R7: While a processor's external mode is on, all of its sources count as routable, whatever `routeCap` says.
- R8: A routing register holds an enable in bit 7 and a pin number in bits 2:0, and both read back as written while the source is routable.
- R9: While a source is not routable, writes to its routing register are ignored and the source drives default pin `DEF_PIN` (0).
- R10: A routable source whose routing enable is clear, or whose pin number is 6 or 7, drives no pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 5 | Window bit and register offset |
| wrData | input | 32 | Write data |
| reqCpu | input | 2 | Index of the requesting processor |
| rdData | output | 32 | Combinational read data for `addr` and `reqCpu` |
| srcPend | input | 20 | Raw pending levels, 5 per processor, processor 0 lowest |
| routeCap | input | 4 | Routing capability: timer, perf counter, debug, software |
| irqPin | output | 24 | Interrupt pins, 6 per processor, processor 0 lowest |

## Verification
The bench checks that a processor's accesses reach the right copy. One processor writes a mask through the other window, and the bench reads it back both from the target processor and from the writer. A design that ignored the target index would change the writer's own mask. A write to the target index through the other window is checked for having no effect. The routing corner cases are also covered. A map write to a non-routable source is checked, and a design that accepted it would move that source off the default pin. Switching external mode on is checked too: it must release a source from the default pin onto its own (still disabled) routing. Out-of-range pin numbers are checked as well, and a design that wrapped them would raise a wrong pin.

// File: rtl/lirq_pkg.sv
package lirq_pkg;
  localparam int NCPU   = 4;
  localparam int CPU_W  = $clog2(NCPU);
  localparam int NSRC   = 5;
  localparam int SRC_W  = 3;
  localparam int NCAP   = 4;
  localparam int NPIN   = 6;
  localparam int PIN_W  = 3;
  localparam int DW     = 32;
  localparam int AW     = 5;
  localparam int MAP_EN_BIT = 7;

  localparam logic [3:0] OFF_CTL   = 4'h0;
  localparam logic [3:0] OFF_PEND  = 4'h1;
  localparam logic [3:0] OFF_MASK  = 4'h2;
  localparam logic [3:0] OFF_CLR   = 4'h3;
  localparam logic [3:0] OFF_SET   = 4'h4;
  localparam logic [3:0] OFF_OTHER = 4'h5;
  localparam logic [3:0] OFF_MAP0  = 4'h8;

  typedef struct packed {
    logic              maskSet;
    logic              maskClr;
    logic              mapWr;
    logic              ctlWr;
    logic              otherRd;
    logic [CPU_W-1:0]  tgt;
    logic [SRC_W-1:0]  srcSel;
    logic [3:0]        off;
  } strobe_t;

  // software interrupts share one capability bit
  function automatic int capIdx(input int s);
    return (s < NCAP - 1) ? s : NCAP - 1;
  endfunction
endpackage

// File: rtl/lirq_ctrl.sv
module lirq_ctrl
  import lirq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wrEn,
  input  logic [AW-1:0]         addr,
  input  logic [DW-1:0]         wrData,
  input  logic [CPU_W-1:0]      reqCpu,
  output strobe_t               strb,
  output logic [DW-1:0]         otherVal
);
  logic             winOther;
  logic [3:0]       off;
  logic [CPU_W-1:0] otherQ [NCPU];
  logic [CPU_W-1:0] tgt;
  logic             unusedCtl;

  assign winOther  = addr[AW-1];
  assign off       = addr[3:0];
  assign unusedCtl = ^wrData[DW-1:CPU_W];

  for (genvar c = 0; c < NCPU; c++) begin : g_other
    always_ff @(posedge clk) begin
      if (rst) begin
        otherQ[c] <= '0;
      end else if (wrEn && !winOther && off == OFF_OTHER && reqCpu == CPU_W'(c)) begin
        otherQ[c] <= wrData[CPU_W-1:0];
      end
    end
  end

  assign tgt      = winOther ? otherQ[reqCpu] : reqCpu;
  assign otherVal = DW'(otherQ[reqCpu]);

  always_comb begin
    strb         = '0;
    strb.tgt     = tgt;
    strb.off     = off;
    strb.srcSel  = off[SRC_W-1:0];
    strb.maskSet = wrEn && off == OFF_SET;
    strb.maskClr = wrEn && off == OFF_CLR;
    strb.ctlWr   = wrEn && off == OFF_CTL;
    strb.mapWr   = wrEn && off[3] && (off[SRC_W-1:0] < SRC_W'(NSRC));
    strb.otherRd = !winOther && off == OFF_OTHER;
  end
endmodule

// File: rtl/lirq_regs.sv
module lirq_regs
  import lirq_pkg::*;
#(
  parameter int DEF_PIN = 0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  strobe_t               strb,
  input  logic [DW-1:0]         wrData,
  input  logic [DW-1:0]         otherVal,
  input  logic [NCPU*NSRC-1:0]  srcPend,
  input  logic [NCAP-1:0]       routeCap,
  output logic [DW-1:0]         rdData,
  output logic [NCPU*NPIN-1:0]  irqPin,
  output logic [NCPU*NSRC-1:0]  maskAll
);
  logic [NCPU*DW-1:0] rdFlat;
  logic               unusedData;

  assign unusedData = ^{wrData[DW-1:MAP_EN_BIT+1], wrData[MAP_EN_BIT-1:NSRC]};

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    logic [NSRC-1:0]  maskQ;
    logic [NSRC-1:0]  enQ;
    logic [PIN_W-1:0] pinQ [NSRC];
    logic             extQ;
    logic [NSRC-1:0]  route;
    logic [NSRC-1:0]  pend;
    logic [NSRC-1:0]  act;
    logic             hit;
    logic [DW-1:0]    rdC;

    assign pend = srcPend[c*NSRC +: NSRC];
    assign hit  = (strb.tgt == CPU_W'(c));
    assign act  = pend & maskQ;

    for (genvar s = 0; s < NSRC; s++) begin : g_route
      assign route[s] = extQ | routeCap[capIdx(s)];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        maskQ <= '0;
        extQ  <= 1'b0;
      end else if (hit) begin
        if (strb.maskSet) maskQ <= maskQ | wrData[NSRC-1:0];
        else if (strb.maskClr) maskQ <= maskQ & ~wrData[NSRC-1:0];
        if (strb.ctlWr) extQ <= wrData[0];
      end
    end

    always_ff @(posedge clk) begin
      for (int s = 0; s < NSRC; s++) begin
        if (rst) begin
          enQ[s]  <= 1'b0;
          pinQ[s] <= '0;
        end else if (hit && strb.mapWr && strb.srcSel == SRC_W'(s) && route[s]) begin
          enQ[s]  <= wrData[MAP_EN_BIT];
          pinQ[s] <= wrData[PIN_W-1:0];
        end
      end
    end

    for (genvar p = 0; p < NPIN; p++) begin : g_pin
      logic [NSRC-1:0] toPin;
      for (genvar s = 0; s < NSRC; s++) begin : g_dst
        assign toPin[s] = route[s] ? (enQ[s] && pinQ[s] == PIN_W'(p)) : (DEF_PIN == p);
      end
      assign irqPin[c*NPIN + p] = |(act & toPin);
    end

    always_comb begin
      rdC = '0;
      case (strb.off)
        OFF_CTL:  rdC[NCAP:0]   = {routeCap, extQ};
        OFF_PEND: rdC[NSRC-1:0] = pend;
        OFF_MASK: rdC[NSRC-1:0] = maskQ;
        default: begin
          for (int s = 0; s < NSRC; s++) begin
            if (strb.off == OFF_MAP0 + 4'(s)) begin
              rdC[MAP_EN_BIT]  = enQ[s];
              rdC[PIN_W-1:0]   = pinQ[s];
            end
          end
        end
      endcase
    end

    assign rdFlat[c*DW +: DW]     = rdC;
    assign maskAll[c*NSRC +: NSRC] = maskQ;
  end

  always_comb begin
    rdData = '0;
    if (strb.otherRd) begin
      rdData = otherVal;
    end else begin
      for (int c = 0; c < NCPU; c++) begin
        if (strb.tgt == CPU_W'(c)) rdData = rdFlat[c*DW +: DW];
      end
    end
  end
endmodule

// File: rtl/lirq_unit.sv
module lirq_unit
  import lirq_pkg::*;
#(
  parameter int DEF_PIN = 0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wrEn,
  input  logic [AW-1:0]         addr,
  input  logic [DW-1:0]         wrData,
  input  logic [CPU_W-1:0]      reqCpu,
  output logic [DW-1:0]         rdData,
  input  logic [NCPU*NSRC-1:0]  srcPend,
  input  logic [NCAP-1:0]       routeCap,
  output logic [NCPU*NPIN-1:0]  irqPin
);
  strobe_t                strb;
  logic [DW-1:0]          otherVal;
  logic [NCPU*NSRC-1:0]   maskAll;

  lirq_ctrl u_ctrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .reqCpu(reqCpu), .strb(strb), .otherVal(otherVal)
  );

  lirq_regs #(.DEF_PIN(DEF_PIN)) u_regs (
    .clk(clk), .rst(rst), .strb(strb), .wrData(wrData), .otherVal(otherVal),
    .srcPend(srcPend), .routeCap(routeCap), .rdData(rdData),
    .irqPin(irqPin), .maskAll(maskAll)
  );
endmodule

// File: rtl/lirq_chk.sv
module lirq_chk
  import lirq_pkg::*;
(
  input logic                  clk,
  input logic                  rst,
  input logic                  wrEn,
  input logic [AW-1:0]         addr,
  input logic [DW-1:0]         wrData,
  input logic [CPU_W-1:0]      reqCpu,
  input logic [DW-1:0]         rdData,
  input logic [NCPU*NSRC-1:0]  srcPend,
  input logic [NCPU*NPIN-1:0]  irqPin,
  input logic [NCPU*NSRC-1:0]  maskAll
);
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> maskAll == '0);

  p_mask_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !wrEn |=> $stable(maskAll));

  p_pend_raw_r3: assert property (@(posedge clk) disable iff (rst)
    (addr == {1'b0, OFF_PEND}) |-> rdData[NSRC-1:0] == srcPend[reqCpu*NSRC +: NSRC]);

  for (genvar c = 0; c < NCPU; c++) begin : g_c
    p_clr_all_r2: assert property (@(posedge clk) disable iff (rst)
      (wrEn && addr == {1'b0, OFF_CLR} && reqCpu == CPU_W'(c) && &wrData[NSRC-1:0])
      |=> maskAll[c*NSRC +: NSRC] == '0);

    p_set_bits_r2: assert property (@(posedge clk) disable iff (rst)
      (wrEn && addr == {1'b0, OFF_SET} && reqCpu == CPU_W'(c))
      |=> (maskAll[c*NSRC +: NSRC] & $past(wrData[NSRC-1:0])) == $past(wrData[NSRC-1:0]));

    p_pin_needs_act_r4: assert property (@(posedge clk) disable iff (rst)
      (|irqPin[c*NPIN +: NPIN]) |-> |(srcPend[c*NSRC +: NSRC] & maskAll[c*NSRC +: NSRC]));
  end
endmodule

bind lirq_unit lirq_chk u_chk (
  .clk(clk), .rst(rst), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .reqCpu(reqCpu), .rdData(rdData), .srcPend(srcPend), .irqPin(irqPin),
  .maskAll(maskAll)
);

// File: tb/sim_lirq_unit.sv
module sim_lirq_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;
  localparam int NS = 5;
  localparam int NP = 6;
  localparam int DEFP = 0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [1:0]  reqCpu = '0;
  logic [31:0] rdData;
  logic [19:0] srcPend = '0;
  logic [3:0]  routeCap = 4'b0101;
  logic [23:0] irqPin;

  int checks = 0;
  int errors = 0;

  // reference model state
  logic [4:0] mMask [NC];
  logic       mExt  [NC];
  logic [1:0] mOther[NC];
  logic       mEn   [NC][NS];
  logic [2:0] mPin  [NC][NS];

  lirq_unit u0 (
    .clk(clk), .rst(rst), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .reqCpu(reqCpu), .rdData(rdData), .srcPend(srcPend), .routeCap(routeCap),
    .irqPin(irqPin)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic routable(int t, int s);
    int k;
    k = (s < 3) ? s : 3;
    return mExt[t] | routeCap[k];
  endfunction

  function automatic logic [31:0] mRead(logic [4:0] a, int cpu);
    logic [31:0] r;
    int t;
    int off;
    t = a[4] ? int'(mOther[cpu]) : cpu;
    off = int'(a[3:0]);
    r = '0;
    if (off == 0) r[4:0] = {routeCap, mExt[t]};
    else if (off == 1) r[4:0] = srcPend[t*NS +: NS];
    else if (off == 2) r[4:0] = mMask[t];
    else if (off == 5) r = a[4] ? 32'd0 : 32'(mOther[cpu]);
    else if (off >= 8 && off < 8 + NS) begin
      r[7] = mEn[t][off-8];
      r[2:0] = mPin[t][off-8];
    end
    return r;
  endfunction

  function automatic logic [23:0] mPins();
    logic [23:0] r;
    r = '0;
    for (int c = 0; c < NC; c++)
      for (int s = 0; s < NS; s++)
        if (srcPend[c*NS + s] && mMask[c][s]) begin
          if (!routable(c, s)) r[c*NP + DEFP] = 1'b1;
          else if (mEn[c][s] && int'(mPin[c][s]) < NP) r[c*NP + int'(mPin[c][s])] = 1'b1;
        end
    return r;
  endfunction

  task automatic mWrite(logic [4:0] a, logic [31:0] d, int cpu);
    int t;
    int off;
    t = a[4] ? int'(mOther[cpu]) : cpu;
    off = int'(a[3:0]);
    if (off == 0) mExt[t] = d[0];
    else if (off == 3) mMask[t] = mMask[t] & ~d[4:0];
    else if (off == 4) mMask[t] = mMask[t] | d[4:0];
    else if (off == 5) begin if (!a[4]) mOther[cpu] = d[1:0]; end
    else if (off >= 8 && off < 8 + NS) begin
      if (routable(t, off-8)) begin
        mEn[t][off-8] = d[7];
        mPin[t][off-8] = d[2:0];
      end
    end
  endtask

  task automatic expect32(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelCmp();
    expect32("R4 model pins", 32'(irqPin), 32'(mPins()));
    expect32("R5 model read", rdData, mRead(addr, int'(reqCpu)));
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d, int cpu);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d; reqCpu = 2'(cpu);
    #1 modelCmp();
    @(posedge clk);
    mWrite(a, d, cpu);
    #1 wrEn = 1'b0;
  endtask

  task automatic rd(string tag, logic [4:0] a, int cpu, logic [31:0] exp);
    @(negedge clk);
    wrEn = 1'b0; addr = a; reqCpu = 2'(cpu);
    #1 modelCmp();
    expect32(tag, rdData, exp);
  endtask

  task automatic pins(string tag, logic [23:0] exp);
    @(negedge clk);
    wrEn = 1'b0;
    #1 modelCmp();
    expect32(tag, 32'(irqPin), 32'(exp));
  endtask

  task automatic setPend(int cpu, logic [4:0] v);
    @(negedge clk);
    srcPend[cpu*NS +: NS] = v;
  endtask

  initial begin
    for (int c = 0; c < NC; c++) begin
      mMask[c] = '0; mExt[c] = 1'b0; mOther[c] = '0;
      for (int s = 0; s < NS; s++) begin mEn[c][s] = 1'b0; mPin[c][s] = '0; end
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    for (int c = 0; c < NC; c++) begin
      rd("R1 mask after reset", 5'h02, c, 32'h0);
      rd("R1 target after reset", 5'h05, c, 32'h0);
    end
    pins("R1 pins after reset", 24'h0);

    // R3 raw pending regardless of mask
    setPend(1, 5'b10110);
    rd("R3 pending raw", 5'h01, 1, 32'h16);
    pins("R3 no pin while masked", 24'h0);
    setPend(1, 5'b00011);

    // R2 set / clear mask
    wr(5'h04, 32'h03, 1);
    rd("R2 set mask", 5'h02, 1, 32'h03);
    wr(5'h04, 32'h14, 1);
    rd("R2 set keeps others", 5'h02, 1, 32'h17);
    wr(5'h03, 32'h01, 1);
    rd("R2 clear one bit", 5'h02, 1, 32'h16);
    wr(5'h03, 32'hFFFF_FFFF, 1);
    rd("R2 clear all", 5'h02, 1, 32'h0);

    // R8 / R4 routable timer to pin 3
    wr(5'h08, 32'h83, 1);
    rd("R8 map readback", 5'h08, 1, 32'h83);
    wr(5'h04, 32'h01, 1);
    pins("R4 timer on cpu1 pin3", 24'h1 << 9);

    // R9 non-routable perf counter
    wr(5'h09, 32'h84, 1);
    rd("R9 map write ignored", 5'h09, 1, 32'h0);
    wr(5'h04, 32'h02, 1);
    pins("R9 default pin", (24'h1 << 9) | (24'h1 << 6));

    // R7 / R6 external mode makes everything routable
    wr(5'h00, 32'h01, 1);
    rd("R6 control with ext", 5'h00, 1, 32'h0B);
    pins("R10 routable but disabled", 24'h1 << 9);
    wr(5'h09, 32'h84, 1);
    rd("R7 map accepted in ext mode", 5'h09, 1, 32'h84);
    pins("R7 perf on pin4", (24'h1 << 9) | (24'h1 << 10));

    // R10 out-of-range pin number
    wr(5'h08, 32'h87, 1);
    rd("R8 map pin 7 readback", 5'h08, 1, 32'h87);
    pins("R10 pin 7 drives nothing", 24'h1 << 10);

    // R5 other window
    wr(5'h05, 32'h02, 0);
    rd("R5 target readback", 5'h05, 0, 32'h02);
    wr(5'h14, 32'h08, 0);
    rd("R5 target cpu2 mask", 5'h02, 2, 32'h08);
    rd("R5 writer mask untouched", 5'h02, 0, 32'h0);
    rd("R5 other window read", 5'h12, 0, 32'h08);
    wr(5'h15, 32'h03, 0);
    rd("R5 target write via other ignored", 5'h05, 0, 32'h02);
    rd("R5 target slot in other window reads 0", 5'h15, 0, 32'h0);

    // R6 control fields
    rd("R6 control no ext", 5'h00, 3, 32'h0A);
    wr(5'h00, 32'h1F, 3);
    rd("R6 only ext writable", 5'h00, 3, 32'h0B);

    // R2 / R4 clearing everything silences the pins
    setPend(2, 5'b01000);
    pins("R4 sw0 of cpu2 on default pin", (24'h1 << 10) | (24'h1 << 12));
    wr(5'h03, 32'h1F, 1);
    pins("R2 cpu1 quiet after clear", 24'h1 << 12);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule